// File: doc/BRIEF.md
# Interrupt Master Enable and Halt Controller

This block keeps the global interrupt enable of a small 8-bit processor core and its halt state. The decode stage reports each completed instruction with a one-cycle boundary pulse, together with one-hot strobes that mark the disable, enable, return-from-handler and halt instructions. The block combines these strobes with the per-source enable and request vectors. From them it decides when to tell the core to enter an interrupt handler, which handler address to use, when the core must sleep, and when the next opcode fetch must leave the program counter where it is.

The enable instruction takes effect one instruction late. The return-from-handler instruction takes effect at once, and the disable instruction also takes effect at once and cancels a delayed enable. The halt instruction has three outcomes, set by the enable flag and by whether a source is already pending. Control uses two states. In `ST_RUN` the core executes instructions and every boundary is evaluated. In `ST_HALTED` the core sleeps and boundary strobes are ignored. The halt-entry transition `ST_RUN -> ST_HALTED` is taken at a halt boundary when nothing is pending. The wake transition `ST_HALTED -> ST_RUN` is taken in the first cycle in which any source is pending.

Top module: `irq_halt_ctrl`

## Requirements
- R1: After reset the outputs `ime`, `halted`, `irq_dispatch` and `pc_hold` are all 0.
- R2: A boundary carrying `op_di` clears `ime` at the next clock edge.
- R3: A boundary carrying `op_ei` leaves `ime` unchanged. `ime` becomes 1 at the edge that ends the boundary of the next instruction, and that next instruction may be a halt.
- R4: If a boundary carrying `op_di` arrives while an enable is still waiting to take effect, the waiting enable is cancelled and `ime` stays 0 after later boundaries.
- R5: A boundary carrying `op_reti` sets `ime` at the next clock edge, with no delay of one instruction.
- R6: When the enable state that results from an instruction is 1 and a source is pending at its boundary, `irq_dispatch` is high for exactly the next cycle and `ime` reads 0 in that same cycle. No dispatch is issued between boundaries while the core is running.
- R7: A source `i` is pending when `int_enable[i] & int_request[i]` is 1. On a dispatch, the lowest-numbered pending source wins and `irq_vector` = 0x40 + 8*i (for example, 0x50 for source 2 and 0x58 for source 3).
- R8: A halt boundary with the resulting enable at 1 and nothing pending sets `halted`. When a source later becomes pending, `halted` falls and `irq_dispatch` rises in the same cycle. If a source is already pending at the halt boundary, the dispatch is issued at once and `halted` stays 0.
- R9: A halt boundary with the resulting enable at 0 and nothing pending sets `halted`. When a source becomes pending, `halted` falls with no dispatch and `ime` stays 0.
- R10: A halt boundary with the resulting enable at 0 and a source pending does not halt. `pc_hold` is 1 from the next cycle until the edge that ends the following boundary.
- R11: While halted, the boundary pulse and all strobes are ignored, so `ime` keeps its value.
- R12: While `ime` is 0, a pending source at an ordinary boundary produces no dispatch.
- R13: A request whose enable bit is 0 neither dispatches nor wakes a halted core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_done | input | 1 | Pulse marking the cycle in which an instruction completes |
| op_di | input | 1 | Completed instruction is disable-interrupts |
| op_ei | input | 1 | Completed instruction is enable-interrupts |
| op_reti | input | 1 | Completed instruction is return-from-handler |
| op_halt | input | 1 | Completed instruction is halt |
| int_enable | input | NUM_SRC | Per-source enable mask |
| int_request | input | NUM_SRC | Per-source request flags |
| ime | output | 1 | Global interrupt enable flag |
| irq_dispatch | output | 1 | One-cycle request to enter a handler |
| irq_vector | output | VEC_W | Handler address for the dispatch |
| halted | output | 1 | Core is sleeping |
| pc_hold | output | 1 | Next opcode fetch must not advance the program counter |

## Verification
Every result of this block is registered, so each one appears exactly one clock edge after the stimulus that causes it. For `ime`, `irq_dispatch`, `irq_vector` and `pc_hold` that stimulus is a boundary pulse. For a wake from halt it is the first pending cycle. The driver records each expected value in a queue together with the cycle number in which it is due, usually one cycle ahead and two cycles ahead for the end of a dispatch pulse. The monitor compares only in the cycle named and samples on the falling edge, half a period after the register update. The `pc_hold` window is checked on both sides: it is high in the idle cycle after the halt boundary and low after the next boundary.

// File: rtl/irqh_pkg.sv
package irqh_pkg;

    // Core activity as seen by the controller
    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_HALTED = 1'b1
    } hstate_e;

endpackage

// File: rtl/irqh_prio.sv
module irqh_prio #(
    parameter int NUM_SRC    = 5,
    parameter int VEC_W      = 16,
    parameter int VEC_BASE   = 'h40,
    parameter int VEC_STRIDE = 8,
    localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [VEC_W-1:0]   vec_o
);

    logic [NUM_SRC:0]   seen;
    logic [NUM_SRC-1:0] win;

    assign seen[0] = 1'b0;

    // Lowest index wins: a source is selected only if no lower one is pending
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
        assign win[g]    = pend_i[g] & ~seen[g];
        assign seen[g+1] = seen[g] | pend_i[g];
    end

    assign any_o = seen[NUM_SRC];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (win[i]) idx_o = IDX_W'(i);
        end
    end

    assign vec_o = VEC_W'(VEC_BASE + VEC_STRIDE * int'(idx_o));

endmodule

// File: rtl/irqh_ime.sv
module irqh_ime (
    input  logic clk,
    input  logic rst_n,
    input  logic bnd_i,
    input  logic di_i,
    input  logic ei_i,
    input  logic reti_i,
    input  logic disp_i,
    output logic ime_q_o,
    output logic ime_next_o
);

    logic ime_q;
    logic ei_wait_q;

    // Enable state that results from the instruction at this boundary
    always_comb begin
        if (di_i)           ime_next_o = 1'b0;
        else if (reti_i)    ime_next_o = 1'b1;
        else if (ei_wait_q) ime_next_o = 1'b1;
        else                ime_next_o = ime_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ime_q     <= 1'b0;
            ei_wait_q <= 1'b0;
        end else if (disp_i) begin
            ime_q     <= 1'b0;
            ei_wait_q <= 1'b0;
        end else if (bnd_i) begin
            ime_q     <= ime_next_o;
            ei_wait_q <= ei_i && !di_i && !reti_i;
        end
    end

    assign ime_q_o = ime_q;

    // R2
    di_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_i && di_i |=> !ime_q);

    // R5
    reti_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_i && reti_i && !di_i && !disp_i |=> ime_q);

    // R3
    ei_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_i && ei_i && !ei_wait_q && !ime_q && !reti_i |=> !ime_q);

    // R4
    ei_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_i && di_i |=> !ei_wait_q);

endmodule

// File: rtl/irqh_fsm.sv
module irqh_fsm
    import irqh_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_done_i,
    input  logic             halt_i,
    input  logic             pend_any_i,
    input  logic             ime_q_i,
    input  logic             ime_next_i,
    input  logic [VEC_W-1:0] vec_i,
    output logic             bnd_o,
    output logic             disp_now_o,
    output logic             disp_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             halted_o,
    output logic             pc_hold_o
);

    hstate_e    state_q, state_d;
    logic       hold_d, hold_q;
    logic       disp_q;
    logic [VEC_W-1:0] vec_q;

    assign bnd_o = (state_q == ST_RUN) && instr_done_i;

    always_comb begin
        state_d    = state_q;
        disp_now_o = 1'b0;
        hold_d     = hold_q;
        unique case (state_q)
            ST_RUN: begin
                disp_now_o = bnd_o && ime_next_i && pend_any_i;
                if (bnd_o) begin
                    hold_d = halt_i && !ime_next_i && pend_any_i;
                    if (halt_i && !pend_any_i) state_d = ST_HALTED;
                end
            end
            ST_HALTED: begin
                hold_d     = 1'b0;
                disp_now_o = pend_any_i && ime_q_i;
                if (pend_any_i) state_d = ST_RUN;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_q <= 1'b0;
            vec_q  <= '0;
            hold_q <= 1'b0;
        end else begin
            disp_q <= disp_now_o;
            hold_q <= hold_d;
            if (disp_now_o) vec_q <= vec_i;
        end
    end

    assign disp_o    = disp_q;
    assign vec_o     = vec_q;
    assign pc_hold_o = hold_q;
    assign halted_o  = (state_q == ST_HALTED);

    // R8
    wake_on_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HALTED && pend_any_i |=> state_q == ST_RUN);

    // R10
    hold_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> state_q == ST_RUN);

    // R11
    halted_ignores_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HALTED && !pend_any_i |=> state_q == ST_HALTED);

endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl #(
    parameter int NUM_SRC    = 5,
    parameter int VEC_W      = 16,
    parameter int VEC_BASE   = 'h40,
    parameter int VEC_STRIDE = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_done,
    input  logic               op_di,
    input  logic               op_ei,
    input  logic               op_reti,
    input  logic               op_halt,
    input  logic [NUM_SRC-1:0] int_enable,
    input  logic [NUM_SRC-1:0] int_request,
    output logic               ime,
    output logic               irq_dispatch,
    output logic [VEC_W-1:0]   irq_vector,
    output logic               halted,
    output logic               pc_hold
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0] pend_w;
    logic               pend_any;
    logic [IDX_W-1:0]   prio_idx;
    logic [VEC_W-1:0]   prio_vec;
    logic               bnd;
    logic               disp_now;
    logic               ime_q;
    logic               ime_next;

    assign pend_w = int_enable & int_request;

    irqh_prio #(
        .NUM_SRC   (NUM_SRC),
        .VEC_W     (VEC_W),
        .VEC_BASE  (VEC_BASE),
        .VEC_STRIDE(VEC_STRIDE)
    ) prio_i (
        .pend_i(pend_w),
        .any_o (pend_any),
        .idx_o (prio_idx),
        .vec_o (prio_vec)
    );

    irqh_ime ime_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bnd_i     (bnd),
        .di_i      (op_di),
        .ei_i      (op_ei),
        .reti_i    (op_reti),
        .disp_i    (disp_now),
        .ime_q_o   (ime_q),
        .ime_next_o(ime_next)
    );

    irqh_fsm #(
        .VEC_W(VEC_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_done_i(instr_done),
        .halt_i      (op_halt),
        .pend_any_i  (pend_any),
        .ime_q_i     (ime_q),
        .ime_next_i  (ime_next),
        .vec_i       (prio_vec),
        .bnd_o       (bnd),
        .disp_now_o  (disp_now),
        .disp_o      (irq_dispatch),
        .vec_o       (irq_vector),
        .halted_o    (halted),
        .pc_hold_o   (pc_hold)
    );

    assign ime = ime_q;

    // R6
    disp_clears_ime_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dispatch |-> !ime);

    // R7
    prio_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_any |-> pend_w[prio_idx] &&
                     ((pend_w & ~({NUM_SRC{1'b1}} << prio_idx)) == '0));

    // R8
    halt_disp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dispatch |-> !halted);

    // R13
    no_pend_no_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_any |=> !irq_dispatch);

endmodule

// File: tb/irq_halt_ctrl_tb_top.sv
module irq_halt_ctrl_tb_top;

    localparam int NSRC = 5;
    localparam int F_IME = 0, F_HALT = 1, F_DISP = 2, F_VEC = 3, F_HOLD = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            instr_done, op_di, op_ei, op_reti, op_halt;
    logic [NSRC-1:0] ien, ireq;
    logic            ime, disp, halted, pc_hold;
    logic [15:0]     vec;

    always #5 clk = ~clk;

    irq_halt_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done),
        .op_di(op_di), .op_ei(op_ei), .op_reti(op_reti), .op_halt(op_halt),
        .int_enable(ien), .int_request(ireq),
        .ime(ime), .irq_dispatch(disp), .irq_vector(vec),
        .halted(halted), .pc_hold(pc_hold)
    );

    typedef struct {
        int    cyc;
        string req;
        int    fld;
        int    val;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int fld_val(int f);
        case (f)
            F_IME:   return int'(ime);
            F_HALT:  return int'(halted);
            F_DISP:  return int'(disp);
            F_VEC:   return int'(vec);
            default: return int'(pc_hold);
        endcase
    endfunction

    // Monitor: compares every queued item in the cycle it is due
    always @(negedge clk) begin
        int i;
        i = 0;
        while (i < q.size()) begin
            if (q[i].cyc == cyc) begin
                n_chk++;
                if (fld_val(q[i].fld) != q[i].val) begin
                    n_fail++;
                    $display("FAIL %s field %0d cycle %0d: actual %0h expected %0h",
                             q[i].req, q[i].fld, cyc, fld_val(q[i].fld), q[i].val);
                end
                q.delete(i);
            end else begin
                i++;
            end
        end
    end

    task automatic expect_f(int dly, string req, int f, int v);
        exp_t e;
        e.cyc = cyc + dly; e.req = req; e.fld = f; e.val = v;
        q.push_back(e);
    endtask

    task automatic issue(logic di, logic ei, logic reti, logic hlt);
        instr_done = 1'b1;
        op_di = di; op_ei = ei; op_reti = reti; op_halt = hlt;
    endtask

    task automatic nxt();
        @(negedge clk);
        instr_done = 1'b0;
        op_di = 1'b0; op_ei = 1'b0; op_reti = 1'b0; op_halt = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        instr_done = 0; op_di = 0; op_ei = 0; op_reti = 0; op_halt = 0;
        ien = '1; ireq = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_f(1, "R1", F_IME, 0);  expect_f(1, "R1", F_HALT, 0);
        expect_f(1, "R1", F_DISP, 0); expect_f(1, "R1", F_HOLD, 0);
        nxt();

        // R5 immediate enable on return
        issue(0, 0, 1, 0); expect_f(1, "R5", F_IME, 1); nxt();
        // R2 immediate disable
        issue(1, 0, 0, 0); expect_f(1, "R2", F_IME, 0); nxt();
        // R3 delayed enable
        issue(0, 1, 0, 0); expect_f(1, "R3", F_IME, 0); nxt();
        issue(0, 0, 0, 0); expect_f(1, "R3", F_IME, 1); nxt();
        // R4 disable cancels waiting enable
        issue(1, 0, 0, 0); nxt();
        issue(0, 1, 0, 0); nxt();
        issue(1, 0, 0, 0); expect_f(1, "R4", F_IME, 0); nxt();
        issue(0, 0, 0, 0); expect_f(1, "R4", F_IME, 0); nxt();

        // R12 pending with enable off
        ireq = 5'b00100;
        issue(0, 0, 0, 0); expect_f(1, "R12", F_DISP, 0); expect_f(1, "R12", F_IME, 0); nxt();

        // R6 / R7 dispatch after return, sources 2 and 4 pending
        ireq = 5'b10100;
        issue(0, 0, 1, 0);
        expect_f(1, "R6", F_DISP, 1); expect_f(1, "R7", F_VEC, 'h50);
        expect_f(1, "R6", F_IME, 0);  expect_f(2, "R6", F_DISP, 0);
        nxt(); nxt();

        // R13 request masked by enable
        ireq = '0;
        issue(0, 0, 1, 0); nxt();
        ien = '0; ireq = '1;
        issue(0, 0, 0, 0); expect_f(1, "R13", F_DISP, 0); expect_f(1, "R13", F_IME, 1); nxt();

        // R6 no dispatch between boundaries, R7 sources 3 and 4
        ien = '1; ireq = 5'b11000;
        expect_f(1, "R6", F_DISP, 0); nxt();
        issue(0, 0, 0, 0); expect_f(1, "R7", F_DISP, 1); expect_f(1, "R7", F_VEC, 'h58); nxt();

        // R8 halt with enable on
        ireq = '0;
        issue(0, 0, 1, 0); nxt();
        issue(0, 0, 0, 1); expect_f(1, "R8", F_HALT, 1); expect_f(1, "R8", F_IME, 1); nxt();
        nxt(); nxt();
        // R11 strobes ignored while halted
        issue(1, 0, 0, 0); expect_f(1, "R11", F_IME, 1); expect_f(1, "R11", F_HALT, 1); nxt();
        ireq = 5'b00001;
        expect_f(1, "R8", F_DISP, 1); expect_f(1, "R8", F_HALT, 0);
        expect_f(1, "R8", F_VEC, 'h40); expect_f(1, "R8", F_IME, 0);
        nxt();
        ireq = '0; nxt();

        // R9 halt with enable off, R13 masked request does not wake
        issue(0, 0, 0, 1); expect_f(1, "R9", F_HALT, 1); nxt();
        ien = '0; ireq = 5'b00010;
        expect_f(1, "R13", F_HALT, 1); nxt();
        ien = '1;
        expect_f(1, "R9", F_HALT, 0); expect_f(1, "R9", F_DISP, 0); expect_f(1, "R9", F_IME, 0);
        nxt();

        // R10 halt with enable off and source pending
        issue(0, 0, 0, 1);
        expect_f(1, "R10", F_HALT, 0); expect_f(1, "R10", F_HOLD, 1); expect_f(1, "R10", F_DISP, 0);
        nxt();
        expect_f(1, "R10", F_HOLD, 1); nxt();
        issue(0, 0, 0, 0); expect_f(1, "R10", F_HOLD, 0); nxt();

        // R8 halt with enable on and source already pending
        ireq = '0;
        issue(0, 0, 1, 0); nxt();
        ireq = 5'b01000;
        issue(0, 0, 0, 1);
        expect_f(1, "R8", F_DISP, 1); expect_f(1, "R8", F_VEC, 'h58); expect_f(1, "R8", F_HALT, 0);
        nxt();
        ireq = '0; nxt();

        // R3 enable maturing on a halt instruction
        issue(0, 1, 0, 0); nxt();
        issue(0, 0, 0, 1); expect_f(1, "R3", F_IME, 1); expect_f(1, "R8", F_HALT, 1); nxt();
        ireq = 5'b10000;
        expect_f(1, "R8", F_DISP, 1); expect_f(1, "R7", F_VEC, 'h60); nxt();
        ireq = '0;
        repeat (3) nxt();

        while (q.size() > 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL %s: actual unchecked expected checked", q[0].req);
            void'(q.pop_front());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule